// File: doc/BRIEF.md
# Read/Write Turnaround Scheduler for Two Pseudo Channels

This block chooses the data-bus direction (read or write) for each pseudo channel of a memory channel and selects which queued request that channel issues next. The read and write request queues are shared between the pseudo channels. Every entry carries a channel tag, and each channel's logic looks only at entries that carry its own tag. Bank timing and address decode are handled outside the block: each entry arrives with a ready flag (its timing is satisfied) and a row-hit flag (its row is already open).

Within the current direction, a channel picks in first-ready, first-come-first-served order. Entry index 0 is the oldest. A ready row hit beats any older ready entry that is not a hit. Turning the bus around costs bandwidth, so a channel must issue a minimum number of bursts in the current direction before it may turn, as long as the current direction still has requests for it. The minimums are set separately for reads and writes, and both default to 64. If a channel's current-direction queue runs empty while the other direction holds requests for it, the channel turns at once. Each turn takes one idle cycle and starts a new burst count.

Top module: `rwt_sched`

## Requirements
- R1: While reset is high, and in the first cycle after it, every channel is in read direction (`bus_wr` = 0) and issues no grant when the queues are empty.
- R2: A channel grants only entries whose tag equals its own index (tag 0 is channel 0, tag 1 is channel 1). Its occupancy checks count only its own entries.
- R3: Among the channel's ready entries in the current-direction queue, a row-hit entry is granted before any non-hit entry. Among hits, the lowest index wins.
- R4: When no ready row hit exists, the lowest-index ready entry of the channel is granted.
- R5: A grant names a valid, ready entry of the current-direction queue. If no such entry exists, `gnt_vld` is 0, and a hit that is not ready is never granted.
- R6: In read direction, a channel does not turn to write until it has issued MIN_RD read grants since its last turn, while its read queue holds entries, even when none of them is ready.
- R7: In write direction, a channel does not turn to read until it has issued MIN_WR write grants since its last turn, while its write queue holds entries.
- R8: If the channel's current-direction queue holds none of its entries and the other queue holds at least one, the channel turns regardless of its burst count.
- R9: In the cycle a turn is decided, the channel issues no grant. `bus_wr` flips in the next cycle and the burst count restarts from zero.
- R10: With no entries of its own in the other queue, a channel keeps its direction and keeps granting beyond the minimum.
- R11: The two channels keep separate directions and burst counts. Traffic on one channel does not change the grants or direction of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_vld | input | DEPTH | Read queue entry occupied |
| rd_tag | input | DEPTH x PCW | Read entry pseudo channel tag |
| rd_rdy | input | DEPTH | Read entry timing satisfied |
| rd_hit | input | DEPTH | Read entry targets an open row |
| wr_vld | input | DEPTH | Write queue entry occupied |
| wr_tag | input | DEPTH x PCW | Write entry pseudo channel tag |
| wr_rdy | input | DEPTH | Write entry timing satisfied |
| wr_hit | input | DEPTH | Write entry targets an open row |
| gnt_vld | output | NUM_PC | Channel issues a burst this cycle |
| gnt_idx | output | NUM_PC x IDXW | Queue index granted; queue chosen by bus_wr |
| bus_wr | output | NUM_PC | Channel direction: 0 read, 1 write |

## Verification
The selection is tried with four queue patterns. The first mixes tags with an older hit owned by the other channel, which separates tag filtering from hit priority. The second has no hits and a younger ready entry behind an older entry that is not ready, which separates age order from readiness. Turnaround is driven by steady traffic in both directions, which exposes the exact cycle of the minimum-burst turn and its idle cycle. It is also driven by a queue that is not ready but occupied, which must hold the direction, and by a queue that drains, which must force an early turn while the other channel keeps granting.

// File: rtl/rwt_pkg.sv
`timescale 1ns/1ps
package rwt_pkg;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned width_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rwt_own_mask.sv
`timescale 1ns/1ps
module rwt_own_mask #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned PCW   = 1,
    parameter int unsigned PC_ID = 0
) (
    input  logic [DEPTH-1:0]          vld,
    input  logic [DEPTH-1:0][PCW-1:0] tag,
    output logic [DEPTH-1:0]          own,
    output logic                      any
);
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            own[i] = vld[i] && (tag[i] == PCW'(PC_ID));
        end
    end

    assign any = |own;
endmodule

// File: rtl/rwt_pick.sv
`timescale 1ns/1ps
module rwt_pick #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned IDXW  = 6
) (
    input  logic [DEPTH-1:0] cand,
    input  logic [DEPTH-1:0] hit,
    output logic             found,
    output logic [IDXW-1:0]  idx
);
    logic [DEPTH-1:0] hit_cand;
    logic [DEPTH-1:0] pool;

    assign hit_cand = cand & hit;
    assign pool     = (|hit_cand) ? hit_cand : cand;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (pool[i]) begin
                found = 1'b1;
                idx   = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/rwt_turn_ctrl.sv
`timescale 1ns/1ps
module rwt_turn_ctrl
    import rwt_pkg::*;
#(
    parameter int unsigned MIN_RD = 64,
    parameter int unsigned MIN_WR = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_any,
    input  logic wr_any,
    input  logic found,
    output logic issue,
    output dir_e dir
);
    localparam int unsigned CMAX = max_u(max_u(MIN_RD, MIN_WR), 1);
    localparam int unsigned CNTW = $clog2(CMAX + 1);
    localparam logic [CNTW-1:0] LIM_RD  = CNTW'(MIN_RD);
    localparam logic [CNTW-1:0] LIM_WR  = CNTW'(MIN_WR);
    localparam logic [CNTW-1:0] CNT_TOP = CNTW'(CMAX);

    logic [CNTW-1:0] bursts;
    logic            cur_any;
    logic            oth_any;
    logic [CNTW-1:0] limit;
    logic            turn_now;

    always_comb begin
        cur_any  = (dir == DIR_WR) ? wr_any : rd_any;
        oth_any  = (dir == DIR_WR) ? rd_any : wr_any;
        limit    = (dir == DIR_WR) ? LIM_WR : LIM_RD;
        turn_now = oth_any && ((bursts >= limit) || !cur_any);
        issue    = found && !turn_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir    <= DIR_RD;
            bursts <= '0;
        end else if (turn_now) begin
            dir    <= (dir == DIR_WR) ? DIR_RD : DIR_WR;
            bursts <= '0;
        end else if (issue && (bursts != CNT_TOP)) begin
            bursts <= bursts + 1'b1;
        end
    end
endmodule

// File: rtl/rwt_sched.sv
`timescale 1ns/1ps
module rwt_sched
    import rwt_pkg::*;
#(
    parameter  int unsigned NUM_PC = 2,
    parameter  int unsigned DEPTH  = 64,
    parameter  int unsigned MIN_RD = 64,
    parameter  int unsigned MIN_WR = 64,
    localparam int unsigned PCW    = width_for(NUM_PC),
    localparam int unsigned IDXW   = width_for(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [DEPTH-1:0]           rd_vld,
    input  logic [DEPTH-1:0][PCW-1:0]  rd_tag,
    input  logic [DEPTH-1:0]           rd_rdy,
    input  logic [DEPTH-1:0]           rd_hit,
    input  logic [DEPTH-1:0]           wr_vld,
    input  logic [DEPTH-1:0][PCW-1:0]  wr_tag,
    input  logic [DEPTH-1:0]           wr_rdy,
    input  logic [DEPTH-1:0]           wr_hit,
    output logic [NUM_PC-1:0]          gnt_vld,
    output logic [NUM_PC-1:0][IDXW-1:0] gnt_idx,
    output logic [NUM_PC-1:0]          bus_wr
);
    for (genvar p = 0; p < NUM_PC; p++) begin : g_pc
        logic [DEPTH-1:0] rd_own, wr_own;
        logic             rd_any, wr_any;
        logic [DEPTH-1:0] cand, hits;
        logic             found, issue;
        logic [IDXW-1:0]  pick_idx;
        dir_e             dir;

        rwt_own_mask #(.DEPTH(DEPTH), .PCW(PCW), .PC_ID(p)) u_rd_mask (
            .vld(rd_vld), .tag(rd_tag), .own(rd_own), .any(rd_any)
        );

        rwt_own_mask #(.DEPTH(DEPTH), .PCW(PCW), .PC_ID(p)) u_wr_mask (
            .vld(wr_vld), .tag(wr_tag), .own(wr_own), .any(wr_any)
        );

        always_comb begin
            if (dir == DIR_WR) begin
                cand = wr_own & wr_rdy;
                hits = wr_hit;
            end else begin
                cand = rd_own & rd_rdy;
                hits = rd_hit;
            end
        end

        rwt_pick #(.DEPTH(DEPTH), .IDXW(IDXW)) u_pick (
            .cand(cand), .hit(hits), .found(found), .idx(pick_idx)
        );

        rwt_turn_ctrl #(.MIN_RD(MIN_RD), .MIN_WR(MIN_WR)) u_turn (
            .clk(clk), .rst(rst), .rd_any(rd_any), .wr_any(wr_any),
            .found(found), .issue(issue), .dir(dir)
        );

        assign gnt_vld[p] = issue;
        assign gnt_idx[p] = pick_idx;
        assign bus_wr[p]  = (dir == DIR_WR);
    end
endmodule

// File: rtl/rwt_sched_chk.sv
`timescale 1ns/1ps
module rwt_sched_chk
    import rwt_pkg::*;
#(
    parameter  int unsigned NUM_PC = 2,
    parameter  int unsigned DEPTH  = 64,
    parameter  int unsigned MIN_RD = 64,
    parameter  int unsigned MIN_WR = 64,
    localparam int unsigned PCW    = width_for(NUM_PC),
    localparam int unsigned IDXW   = width_for(DEPTH)
) (
    input logic                        clk,
    input logic                        rst,
    input logic [DEPTH-1:0]            rd_vld,
    input logic [DEPTH-1:0][PCW-1:0]   rd_tag,
    input logic [DEPTH-1:0]            rd_rdy,
    input logic [DEPTH-1:0]            rd_hit,
    input logic [DEPTH-1:0]            wr_vld,
    input logic [DEPTH-1:0][PCW-1:0]   wr_tag,
    input logic [DEPTH-1:0]            wr_rdy,
    input logic [DEPTH-1:0]            wr_hit,
    input logic [NUM_PC-1:0]           gnt_vld,
    input logic [NUM_PC-1:0][IDXW-1:0] gnt_idx,
    input logic [NUM_PC-1:0]           bus_wr
);
    localparam int unsigned CMAX = max_u(max_u(MIN_RD, MIN_WR), 1);

    for (genvar p = 0; p < NUM_PC; p++) begin : g_chk
        logic rd_have, wr_have, hit_avail, sel_ok, sel_hit, turn_ok;
        logic prev_dir;
        int unsigned seen, seen_eff;

        always_comb begin
            rd_have   = 1'b0;
            wr_have   = 1'b0;
            hit_avail = 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                if (rd_vld[i] && rd_tag[i] == PCW'(p)) rd_have = 1'b1;
                if (wr_vld[i] && wr_tag[i] == PCW'(p)) wr_have = 1'b1;
                if (bus_wr[p]) begin
                    if (wr_vld[i] && wr_rdy[i] && wr_hit[i] && wr_tag[i] == PCW'(p)) hit_avail = 1'b1;
                end else begin
                    if (rd_vld[i] && rd_rdy[i] && rd_hit[i] && rd_tag[i] == PCW'(p)) hit_avail = 1'b1;
                end
            end
            if (bus_wr[p]) begin
                sel_ok  = wr_vld[gnt_idx[p]] && wr_rdy[gnt_idx[p]] && (wr_tag[gnt_idx[p]] == PCW'(p));
                sel_hit = wr_hit[gnt_idx[p]];
            end else begin
                sel_ok  = rd_vld[gnt_idx[p]] && rd_rdy[gnt_idx[p]] && (rd_tag[gnt_idx[p]] == PCW'(p));
                sel_hit = rd_hit[gnt_idx[p]];
            end
            seen_eff = (bus_wr[p] != prev_dir) ? 0 : seen;
            if (bus_wr[p])
                turn_ok = rd_have && ((seen_eff >= MIN_WR) || !wr_have);
            else
                turn_ok = wr_have && ((seen_eff >= MIN_RD) || !rd_have);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_dir <= 1'b0;
                seen     <= 0;
            end else begin
                prev_dir <= bus_wr[p];
                seen     <= (gnt_vld[p] && seen_eff < CMAX) ? seen_eff + 1 : seen_eff;
            end
        end

        // R1
        a_r1_reset_read: assert property (@(posedge clk) rst |=> !bus_wr[p]);

        // R2 and R5
        a_r5_grant_legal: assert property (@(posedge clk) disable iff (rst)
            gnt_vld[p] |-> sel_ok);

        // R3
        a_r3_hit_first: assert property (@(posedge clk) disable iff (rst)
            (gnt_vld[p] && hit_avail) |-> sel_hit);

        // R9
        a_r9_quiet_turn: assert property (@(posedge clk) disable iff (rst)
            (bus_wr[p] != $past(bus_wr[p])) |-> !$past(gnt_vld[p]));

        // R6, R7 and R8
        a_r6_turn_allowed: assert property (@(posedge clk) disable iff (rst)
            (bus_wr[p] != $past(bus_wr[p])) |-> $past(turn_ok));

        // R10
        a_r10_stay: assert property (@(posedge clk) disable iff (rst)
            (bus_wr[p] ? !rd_have : !wr_have) |=> (bus_wr[p] == $past(bus_wr[p])));
    end
endmodule

bind rwt_sched rwt_sched_chk #(
    .NUM_PC(NUM_PC), .DEPTH(DEPTH), .MIN_RD(MIN_RD), .MIN_WR(MIN_WR)
) u_chk (
    .clk(clk), .rst(rst),
    .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_rdy(rd_rdy), .rd_hit(rd_hit),
    .wr_vld(wr_vld), .wr_tag(wr_tag), .wr_rdy(wr_rdy), .wr_hit(wr_hit),
    .gnt_vld(gnt_vld), .gnt_idx(gnt_idx), .bus_wr(bus_wr)
);

// File: tb/test_rwt_sched.sv
`timescale 1ns/1ps
module test_rwt_sched;
    localparam int NPC  = 2;
    localparam int DEP  = 8;
    localparam int MRD  = 4;
    localparam int MWR  = 3;
    localparam int PCW  = 1;
    localparam int IDXW = 3;

    typedef struct {
        int    ch;
        bit    vld;
        int    idx;
        bit    wr;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [DEP-1:0]          rd_vld, rd_rdy, rd_hit, wr_vld, wr_rdy, wr_hit;
    logic [DEP-1:0][PCW-1:0] rd_tag, wr_tag;
    logic [NPC-1:0]            gnt_vld, bus_wr;
    logic [NPC-1:0][IDXW-1:0]  gnt_idx;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    exp_t sb[$];
    event chk_ev;

    always #5 clk = ~clk;

    rwt_sched #(.NUM_PC(NPC), .DEPTH(DEP), .MIN_RD(MRD), .MIN_WR(MWR)) i_rwt_sched (
        .clk(clk), .rst(rst),
        .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_rdy(rd_rdy), .rd_hit(rd_hit),
        .wr_vld(wr_vld), .wr_tag(wr_tag), .wr_rdy(wr_rdy), .wr_hit(wr_hit),
        .gnt_vld(gnt_vld), .gnt_idx(gnt_idx), .bus_wr(bus_wr)
    );

    // monitor: pop expected items and compare against the ports
    always @(chk_ev) begin
        while (sb.size() > 0) begin
            exp_t e;
            bit bad;
            e = sb.pop_front();
            checks++;
            bad = (gnt_vld[e.ch] !== e.vld) || (bus_wr[e.ch] !== e.wr) ||
                  (e.vld && (int'(gnt_idx[e.ch]) != e.idx));
            if (bad) begin
                errors++;
                $display("FAIL %s ch%0d: got vld=%0b idx=%0d wr=%0b, expected vld=%0b idx=%0d wr=%0b",
                         e.req, e.ch, gnt_vld[e.ch], gnt_idx[e.ch], bus_wr[e.ch],
                         e.vld, e.idx, e.wr);
            end
        end
    end

    task automatic expect_ch(input int ch, input bit vld, input int idx, input bit wr, input string req);
        exp_t e;
        e.ch = ch; e.vld = vld; e.idx = idx; e.wr = wr; e.req = req;
        sb.push_back(e);
    endtask

    task automatic sample();
        #1;
        ->chk_ev;
        @(negedge clk);
    endtask

    task automatic clear_q();
        rd_vld = '0; rd_tag = '0; rd_rdy = '0; rd_hit = '0;
        wr_vld = '0; wr_tag = '0; wr_rdy = '0; wr_hit = '0;
    endtask

    task automatic put_rd(input int i, input int pc, input bit rdy, input bit hit);
        rd_vld[i] = 1'b1; rd_tag[i] = PCW'(pc); rd_rdy[i] = rdy; rd_hit[i] = hit;
    endtask

    task automatic put_wr(input int i, input int pc, input bit rdy, input bit hit);
        wr_vld[i] = 1'b1; wr_tag[i] = PCW'(pc); wr_rdy[i] = rdy; wr_hit[i] = hit;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        clear_q();
        repeat (3) @(negedge clk);
        expect_ch(0, 1'b0, 0, 1'b0, "R1");
        expect_ch(1, 1'b0, 0, 1'b0, "R1");
        sample();
        rst = 1'b0;
    endtask

    initial begin
        clear_q();
        @(negedge clk);

        // R1: state in the first cycle after reset
        do_reset();
        expect_ch(0, 1'b0, 0, 1'b0, "R1");
        expect_ch(1, 1'b0, 0, 1'b0, "R1");
        sample();

        // R2, R3, R10: mixed tags, older hit belongs to ch1, no writes
        do_reset();
        put_rd(0, 1, 1'b1, 1'b1);
        put_rd(1, 0, 1'b1, 1'b0);
        put_rd(2, 0, 1'b1, 1'b1);
        put_rd(3, 0, 1'b1, 1'b1);
        for (int j = 0; j < 6; j++) begin
            expect_ch(0, 1'b1, 2, 1'b0, (j < 4) ? "R3" : "R10");
            expect_ch(1, 1'b1, 0, 1'b0, "R2");
            sample();
        end

        // R4, R5: no hits, then older entry not ready, then nothing ready
        do_reset();
        put_rd(0, 1, 1'b1, 1'b0);
        put_rd(1, 0, 1'b1, 1'b0);
        put_rd(3, 0, 1'b1, 1'b0);
        expect_ch(0, 1'b1, 1, 1'b0, "R4");
        expect_ch(1, 1'b1, 0, 1'b0, "R2");
        sample();
        put_rd(1, 0, 1'b0, 1'b0);
        expect_ch(0, 1'b1, 3, 1'b0, "R5");
        sample();
        put_rd(3, 0, 1'b0, 1'b1);
        expect_ch(0, 1'b0, 0, 1'b0, "R5");
        expect_ch(1, 1'b1, 0, 1'b0, "R11");
        sample();

        // R6, R7, R9: steady traffic both directions on ch0
        do_reset();
        put_rd(0, 0, 1'b1, 1'b0);
        put_wr(0, 0, 1'b1, 1'b0);
        for (int j = 0; j < 10; j++) begin
            if (j < 4)       expect_ch(0, 1'b1, 0, 1'b0, "R6");
            else if (j == 4) expect_ch(0, 1'b0, 0, 1'b0, "R9");
            else if (j < 8)  expect_ch(0, 1'b1, 0, 1'b1, "R7");
            else if (j == 8) expect_ch(0, 1'b0, 0, 1'b1, "R9");
            else             expect_ch(0, 1'b1, 0, 1'b0, "R7");
            expect_ch(1, 1'b0, 0, 1'b0, "R11");
            sample();
        end

        // R6: reads present but not ready hold the direction
        do_reset();
        put_rd(0, 0, 1'b0, 1'b0);
        put_wr(2, 0, 1'b1, 1'b0);
        for (int j = 0; j < 3; j++) begin
            expect_ch(0, 1'b0, 0, 1'b0, "R6");
            sample();
        end

        // R8, R11: early turn on an empty queue, ch1 keeps reading
        do_reset();
        put_rd(5, 1, 1'b1, 1'b0);
        put_wr(1, 0, 1'b1, 1'b0);
        expect_ch(0, 1'b0, 0, 1'b0, "R8");
        expect_ch(1, 1'b1, 5, 1'b0, "R11");
        sample();
        expect_ch(0, 1'b1, 1, 1'b1, "R8");
        expect_ch(1, 1'b1, 5, 1'b0, "R11");
        sample();
        wr_vld = '0;
        put_rd(2, 0, 1'b1, 1'b0);
        expect_ch(0, 1'b0, 0, 1'b1, "R8");
        expect_ch(1, 1'b1, 5, 1'b0, "R11");
        sample();
        expect_ch(0, 1'b1, 2, 1'b0, "R8");
        expect_ch(1, 1'b1, 5, 1'b0, "R11");
        sample();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule